// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor core's control path and decides which exception the core enters when more than one request line is active in the same cycle. Each cycle it looks at seven sources: a reset request, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. It also looks at the current status word and program counter and a bit that selects the high vector base. When a source wins, the block registers the whole entry update in one step: the vector fetch address, the new status word with its mode field and interrupt masks rewritten, and one-hot write strobes that tell the register file which banked link register and saved-status register get the old program counter and the old status word.

Request lines are levels that the requester holds. The block never clears them. A request that loses arbitration is taken later, once nothing above it is active. After each entry the block spends one idle cycle. In that cycle the core applies the update, so the next decision sees the new status word.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among requests that are not masked, the winner is the first of: reset, data abort, FIQ, IRQ, prefetch abort, then undefined instruction or software interrupt.
- R2: The vector address is the base plus four times the exception code. The base is 0x00000000 when `hivec_i` is 0 and 0xFFFF0000 when it is 1. The codes are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6 and FIQ 7. Code 5 (offset 0x14) is never produced.
- R3: The new status word carries the target mode in bits 4:0. Reset and software interrupt enter supervisor mode 5'b10011. Undefined instruction enters 5'b11011. Both aborts enter 5'b10111. IRQ enters 5'b10010 and FIQ enters 5'b10001.
- R4: The new status word always has bit 7 (I) set. Bit 6 (F) is set for reset and FIQ; for the other sources it keeps its old value. Every bit other than 7, 6 and 4:0 is copied unchanged.
- R5: On entry, `lr_data_o` equals the sampled `pc_i` and `spsr_data_o` equals the sampled `psr_i`. `lr_we_o` and `spsr_we_o` each carry one bit for the target bank: bit 0 supervisor, bit 1 undefined, bit 2 abort, bit 3 IRQ, bit 4 FIQ.
- R6: An IRQ request has no effect while `psr_i` bit 7 is set. An FIQ request has no effect while `psr_i` bit 6 is set. No other source can be masked.
- R7: While `rst_req_i` is high, no exception is taken. Reset entry happens on the first decision after `rst_req_i` falls.
- R8: `take_o` is high for exactly one cycle per entry, and the cycle after it is always idle. With no eligible request, `take_o` stays low and the strobes stay zero.
- R9: A request that lost arbitration and is still held is taken after the idle cycle that follows the winner's entry.
- R10: Undefined instruction and software interrupt are never requested in the same cycle.
- R11: While the block reset `rst_n` is low, `take_o` and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| rst_req_i | input | 1 | Processor reset request; entry happens when it is released |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| dabt_req_i | input | 1 | Data abort request |
| irq_req_i | input | 1 | Interrupt request |
| fiq_req_i | input | 1 | Fast interrupt request |
| psr_i | input | PSR_W | Current status word |
| pc_i | input | ADDR_W | Current program counter |
| hivec_i | input | 1 | Selects the high vector base |
| take_o | output | 1 | Entry pulse |
| code_o | output | 3 | Code of the exception taken |
| vec_addr_o | output | ADDR_W | Vector fetch address |
| new_psr_o | output | PSR_W | Status word after entry |
| lr_we_o | output | 5 | Banked link register write strobes |
| lr_data_o | output | ADDR_W | Return address to save |
| spsr_we_o | output | 5 | Banked saved-status write strobes |
| spsr_data_o | output | PSR_W | Old status word to save |

## Verification
The checker assumes the instruction path never raises undefined instruction and software interrupt together, because they come from one instruction. It flags that case on the inputs and does not try to resolve it. The stimulus respects this rule: the random patterns clear the software interrupt bit whenever the undefined bit is drawn, and the sweep over every pair of sources skips that one pair. The random status words still cover both mask bits freely, so the masking of IRQ and FIQ is exercised against every mix of other sources.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [2:0] {
      EXC_RST  = 3'd0,
      EXC_UND  = 3'd1,
      EXC_SWI  = 3'd2,
      EXC_PABT = 3'd3,
      EXC_DABT = 3'd4,
      EXC_IRQ  = 3'd6,
      EXC_FIQ  = 3'd7
   } exc_code_e;

   localparam logic [4:0] MODE_USR = 5'b10000;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_ABT = 5'b10111;
   localparam logic [4:0] MODE_UND = 5'b11011;

   localparam int PSR_I_BIT = 7;
   localparam int PSR_F_BIT = 6;

   localparam int NBANK    = 5;
   localparam int BANK_SVC = 0;
   localparam int BANK_UND = 1;
   localparam int BANK_ABT = 2;
   localparam int BANK_IRQ = 3;
   localparam int BANK_FIQ = 4;

   function automatic logic [4:0] mode_of(input exc_code_e c);
      case (c)
         EXC_UND:           return MODE_UND;
         EXC_PABT, EXC_DABT: return MODE_ABT;
         EXC_IRQ:           return MODE_IRQ;
         EXC_FIQ:           return MODE_FIQ;
         default:           return MODE_SVC;
      endcase
   endfunction

   function automatic int bank_of(input exc_code_e c);
      case (c)
         EXC_UND:           return BANK_UND;
         EXC_PABT, EXC_DABT: return BANK_ABT;
         EXC_IRQ:           return BANK_IRQ;
         EXC_FIQ:           return BANK_FIQ;
         default:           return BANK_SVC;
      endcase
   endfunction

   function automatic logic sets_f(input exc_code_e c);
      return (c == EXC_RST) || (c == EXC_FIQ);
   endfunction

endpackage

// File: rtl/exc_reset_edge.sv
module exc_reset_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_req_i,
   input  logic taken_i,
   output logic pend_o
);
   logic req_q;
   logic hold_q;

   // Pending from the release edge until the reset entry is issued.
   assign pend_o = ~rst_req_i & (req_q | hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         req_q  <= rst_req_i;
         hold_q <= pend_o & ~taken_i;
      end
   end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int NSRC = 7
) (
   input  logic      en_i,
   input  logic      rst_block_i,
   input  logic      rst_pend_i,
   input  logic      und_i,
   input  logic      swi_i,
   input  logic      pabt_i,
   input  logic      dabt_i,
   input  logic      irq_i,
   input  logic      fiq_i,
   input  logic      i_mask_i,
   input  logic      f_mask_i,
   output logic      valid_o,
   output exc_code_e code_o
);
   localparam int LVL_W = $clog2(NSRC);

   // Index 0 is the highest priority.
   logic      eligible [NSRC];
   exc_code_e order    [NSRC];

   assign eligible[0] = rst_pend_i;           assign order[0] = EXC_RST;
   assign eligible[1] = dabt_i;               assign order[1] = EXC_DABT;
   assign eligible[2] = fiq_i & ~f_mask_i;    assign order[2] = EXC_FIQ;
   assign eligible[3] = irq_i & ~i_mask_i;    assign order[3] = EXC_IRQ;
   assign eligible[4] = pabt_i;               assign order[4] = EXC_PABT;
   assign eligible[5] = und_i;                assign order[5] = EXC_UND;
   assign eligible[6] = swi_i;                assign order[6] = EXC_SWI;

   logic [LVL_W-1:0] unused_lvl;
   assign unused_lvl = '0;

   always_comb begin
      valid_o = 1'b0;
      code_o  = EXC_RST;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (eligible[k]) begin
            valid_o = 1'b1;
            code_o  = order[k];
         end
      end
      if (!en_i || rst_block_i) valid_o = 1'b0;
   end
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
   import exc_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              PSR_W      = 32,
   parameter logic [ADDR_W-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
   input  exc_code_e         code_i,
   input  logic              hivec_i,
   input  logic [PSR_W-1:0]  psr_i,
   output logic [ADDR_W-1:0] vec_o,
   output logic [PSR_W-1:0]  psr_o,
   output logic [NBANK-1:0]  bank_oh_o
);
   localparam int OFS_W = 5;

   logic [ADDR_W-1:0] base;
   logic [OFS_W-1:0]  ofs;

   assign base  = hivec_i ? HIVEC_BASE : '0;
   assign ofs   = {code_i, 2'b00};
   assign vec_o = base + ADDR_W'(ofs);

   always_comb begin
      psr_o            = psr_i;
      psr_o[4:0]       = mode_of(code_i);
      psr_o[PSR_I_BIT] = 1'b1;
      psr_o[PSR_F_BIT] = psr_i[PSR_F_BIT] | sets_f(code_i);
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_oh_o[g] = (bank_of(code_i) == g);
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                PSR_W      = 32,
   parameter logic [ADDR_W-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req_i,
   input  logic              und_req_i,
   input  logic              swi_req_i,
   input  logic              pabt_req_i,
   input  logic              dabt_req_i,
   input  logic              irq_req_i,
   input  logic              fiq_req_i,
   input  logic [PSR_W-1:0]  psr_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              hivec_i,
   output logic              take_o,
   output logic [2:0]        code_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic [PSR_W-1:0]  new_psr_o,
   output logic [4:0]        lr_we_o,
   output logic [ADDR_W-1:0] lr_data_o,
   output logic [4:0]        spsr_we_o,
   output logic [PSR_W-1:0]  spsr_data_o
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("exc_entry_ctrl: ADDR_W must be at least 8");
   end
   if (PSR_W < 8) begin : g_bad_psr
      $error("exc_entry_ctrl: PSR_W must be at least 8");
   end
   if (HIVEC_BASE[7:0] != 8'h00) begin : g_bad_base
      $error("exc_entry_ctrl: HIVEC_BASE must be 256-byte aligned");
   end

   logic              rst_pend;
   logic              win_valid;
   exc_code_e         win_code;
   logic              fire;
   logic [ADDR_W-1:0] vec_d;
   logic [PSR_W-1:0]  psr_d;
   logic [NBANK-1:0]  bank_oh;

   assign fire = win_valid;

   exc_reset_edge u_rst_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_req_i (rst_req_i),
      .taken_i   (fire && (win_code == EXC_RST)),
      .pend_o    (rst_pend)
   );

   exc_arbiter #(.NSRC(7)) u_arb (
      .en_i        (~take_o),
      .rst_block_i (rst_req_i),
      .rst_pend_i  (rst_pend),
      .und_i       (und_req_i),
      .swi_i       (swi_req_i),
      .pabt_i      (pabt_req_i),
      .dabt_i      (dabt_req_i),
      .irq_i       (irq_req_i),
      .fiq_i       (fiq_req_i),
      .i_mask_i    (psr_i[PSR_I_BIT]),
      .f_mask_i    (psr_i[PSR_F_BIT]),
      .valid_o     (win_valid),
      .code_o      (win_code)
   );

   exc_entry_gen #(
      .ADDR_W     (ADDR_W),
      .PSR_W      (PSR_W),
      .HIVEC_BASE (HIVEC_BASE)
   ) u_gen (
      .code_i    (win_code),
      .hivec_i   (hivec_i),
      .psr_i     (psr_i),
      .vec_o     (vec_d),
      .psr_o     (psr_d),
      .bank_oh_o (bank_oh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o      <= 1'b0;
         code_o      <= 3'd0;
         vec_addr_o  <= '0;
         new_psr_o   <= '0;
         lr_we_o     <= '0;
         lr_data_o   <= '0;
         spsr_we_o   <= '0;
         spsr_data_o <= '0;
      end else begin
         take_o    <= fire;
         lr_we_o   <= fire ? bank_oh : '0;
         spsr_we_o <= fire ? bank_oh : '0;
         if (fire) begin
            code_o      <= win_code;
            vec_addr_o  <= vec_d;
            new_psr_o   <= psr_d;
            lr_data_o   <= pc_i;
            spsr_data_o <= psr_i;
         end
      end
   end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
   import exc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PSR_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_req_i,
   input logic              und_req_i,
   input logic              swi_req_i,
   input logic              take_o,
   input logic [2:0]        code_o,
   input logic [ADDR_W-1:0] vec_addr_o,
   input logic [PSR_W-1:0]  new_psr_o,
   input logic [4:0]        lr_we_o,
   input logic [4:0]        spsr_we_o
);
   assert_one_cycle_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !take_o);

   assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (lr_we_o == 5'd0 && spsr_we_o == 5'd0));

   assert_one_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ($countones(lr_we_o) == 1 && $onehot0(spsr_we_o) && spsr_we_o != 5'd0));

   assert_vec_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (vec_addr_o[4:0] == {code_o, 2'b00} && code_o != 3'd5));

   assert_i_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> new_psr_o[PSR_I_BIT]);

   assert_f_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && (code_o == EXC_FIQ || code_o == EXC_RST)) |-> new_psr_o[PSR_F_BIT]);

   assert_irq_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && code_o == EXC_IRQ) |-> (new_psr_o[4:0] == MODE_IRQ && lr_we_o[BANK_IRQ]));

   assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_i |=> !take_o);

   assert_und_swi_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(und_req_i && swi_req_i));

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R11: assert (!take_o && lr_we_o == 5'd0 && spsr_we_o == 5'd0);
      end
   end
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_req_i  (rst_req_i),
   .und_req_i  (und_req_i),
   .swi_req_i  (swi_req_i),
   .take_o     (take_o),
   .code_o     (code_o),
   .vec_addr_o (vec_addr_o),
   .new_psr_o  (new_psr_o),
   .lr_we_o    (lr_we_o),
   .spsr_we_o  (spsr_we_o)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req_i = 1'b0;
   logic        und_req_i = 1'b0, swi_req_i = 1'b0, pabt_req_i = 1'b0;
   logic        dabt_req_i = 1'b0, irq_req_i = 1'b0, fiq_req_i = 1'b0;
   logic [31:0] psr_i = '0;
   logic [31:0] pc_i = '0;
   logic        hivec_i = 1'b0;
   logic        take_o;
   logic [2:0]  code_o;
   logic [31:0] vec_addr_o, new_psr_o, lr_data_o, spsr_data_o;
   logic [4:0]  lr_we_o, spsr_we_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   exc_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i),
      .und_req_i(und_req_i), .swi_req_i(swi_req_i), .pabt_req_i(pabt_req_i),
      .dabt_req_i(dabt_req_i), .irq_req_i(irq_req_i), .fiq_req_i(fiq_req_i),
      .psr_i(psr_i), .pc_i(pc_i), .hivec_i(hivec_i),
      .take_o(take_o), .code_o(code_o), .vec_addr_o(vec_addr_o),
      .new_psr_o(new_psr_o), .lr_we_o(lr_we_o), .lr_data_o(lr_data_o),
      .spsr_we_o(spsr_we_o), .spsr_data_o(spsr_data_o)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // r bits: 0 und, 1 swi, 2 pabt, 3 dabt, 4 irq, 5 fiq
   function automatic int exp_pick(input logic [5:0] r, input logic [31:0] p);
      if (r[3]) return 4;
      if (r[5] && !p[6]) return 7;
      if (r[4] && !p[7]) return 6;
      if (r[2]) return 3;
      if (r[0]) return 1;
      if (r[1]) return 2;
      return -1;
   endfunction

   function automatic logic [4:0] exp_mode(input int c);
      case (c)
         1: return 5'b11011;
         3, 4: return 5'b10111;
         6: return 5'b10010;
         7: return 5'b10001;
         default: return 5'b10011;
      endcase
   endfunction

   function automatic logic [4:0] exp_bank(input int c);
      case (c)
         1: return 5'b00010;
         3, 4: return 5'b00100;
         6: return 5'b01000;
         7: return 5'b10000;
         default: return 5'b00001;
      endcase
   endfunction

   function automatic logic [31:0] exp_psr(input int c, input logic [31:0] p);
      logic [31:0] q;
      q = p;
      q[4:0] = exp_mode(c);
      q[7] = 1'b1;
      q[6] = p[6] | (c == 0) | (c == 7);
      return q;
   endfunction

   task automatic drive(input logic [5:0] r);
      und_req_i = r[0]; swi_req_i = r[1]; pabt_req_i = r[2];
      dabt_req_i = r[3]; irq_req_i = r[4]; fiq_req_i = r[5];
   endtask

   task automatic check_entry(input int c, input logic [31:0] p, input logic [31:0] pc, input logic hv);
      logic [31:0] base;
      base = hv ? 32'hFFFF_0000 : 32'h0;
      chk(take_o == 1'b1, "R8 take", 64'(take_o), 64'd1);
      chk(code_o == 3'(c), "R1 code", 64'(code_o), 64'(c));
      chk(vec_addr_o == base + 32'(c * 4), "R2 vector", 64'(vec_addr_o), 64'(base + 32'(c * 4)));
      chk(new_psr_o[4:0] == exp_mode(c), "R3 mode", 64'(new_psr_o[4:0]), 64'(exp_mode(c)));
      chk(new_psr_o == exp_psr(c, p), "R4 status", 64'(new_psr_o), 64'(exp_psr(c, p)));
      chk(lr_we_o == exp_bank(c) && spsr_we_o == exp_bank(c), "R5 strobes",
          64'({lr_we_o, spsr_we_o}), 64'({exp_bank(c), exp_bank(c)}));
      chk(lr_data_o == pc && spsr_data_o == p, "R5 saved",
          64'({lr_data_o, spsr_data_o}), 64'({pc, p}));
   endtask

   // One decision: drive at a falling edge, check after one rising edge, then idle.
   task automatic apply(input logic [5:0] r, input logic [31:0] p, input logic [31:0] pc, input logic hv);
      int c;
      c = exp_pick(r, p);
      drive(r); psr_i = p; pc_i = pc; hivec_i = hv;
      @(negedge clk);
      if (c < 0) begin
         chk(take_o == 1'b0, "R6 no take", 64'(take_o), 64'd0);
         chk(lr_we_o == 5'd0, "R8 no strobe", 64'(lr_we_o), 64'd0);
      end else begin
         check_entry(c, p, pc, hv);
      end
      drive(6'd0);
      @(negedge clk);
      chk(take_o == 1'b0, "R8 idle after", 64'(take_o), 64'd0);
   endtask

   initial begin
      #(20000 * 10);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [5:0] r;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk(take_o == 1'b0 && lr_we_o == 5'd0 && spsr_we_o == 5'd0, "R11 reset state",
          64'({take_o, lr_we_o, spsr_we_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: held reset request blocks everything; release enters reset (beats data abort, R1)
      rst_req_i = 1'b1; psr_i = 32'h0000_0010; pc_i = 32'h0000_8000; hivec_i = 1'b1;
      drive(6'b011000);
      @(negedge clk);
      chk(take_o == 1'b0, "R7 held", 64'(take_o), 64'd0);
      @(negedge clk);
      chk(take_o == 1'b0, "R7 still held", 64'(take_o), 64'd0);
      rst_req_i = 1'b0;
      @(negedge clk);
      check_entry(0, 32'h0000_0010, 32'h0000_8000, 1'b1);
      drive(6'd0);
      @(negedge clk);
      chk(take_o == 1'b0, "R7 single reset entry", 64'(take_o), 64'd0);
      @(negedge clk);
      chk(take_o == 1'b0, "R8 quiet", 64'(take_o), 64'd0);

      // R6: masked IRQ and FIQ
      apply(6'b010000, 32'h0000_0090, 32'h100, 1'b0);
      apply(6'b100000, 32'h0000_0050, 32'h104, 1'b0);
      apply(6'b110000, 32'h0000_00D0, 32'h108, 1'b1);
      apply(6'b110000, 32'h0000_0050, 32'h10C, 1'b1);

      // R9: lower request stays pending and is taken after the idle cycle
      psr_i = 32'h0000_0010; pc_i = 32'h200; hivec_i = 1'b0;
      drive(6'b001100);
      @(negedge clk);
      check_entry(4, 32'h0000_0010, 32'h200, 1'b0);
      drive(6'b000100);
      @(negedge clk);
      chk(take_o == 1'b0, "R8 idle", 64'(take_o), 64'd0);
      @(negedge clk);
      chk(take_o == 1'b1 && code_o == 3'd3, "R9 pending taken", 64'(code_o), 64'd3);
      drive(6'd0);
      @(negedge clk);

      // R1: every pair of sources (und+swi excluded, R10)
      for (int i = 0; i < 6; i++) begin
         for (int j = i + 1; j < 6; j++) begin
            if (!(i == 0 && j == 1)) begin
               r = 6'd0; r[i] = 1'b1; r[j] = 1'b1;
               apply(r, 32'h0000_0010 | 32'(i << 8), 32'h1000 + 32'(i * 16 + j), 1'((i + j) % 2));
            end
         end
      end

      // random patterns
      for (int k = 0; k < 300; k++) begin
         r = 6'($urandom);
         if (r[0]) r[1] = 1'b0;
         apply(r, $urandom, $urandom & 32'hFFFF_FFFC, 1'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule